// File: doc/BRIEF.md
# Programmable-Framing Serial Transmitter

This block serialises one character at a time onto a single output line. A character written into its holding register moves into a shift register on the next baud tick once the line is free. It then leaves as a low start bit, five to eight data bits sent least significant first, an optional parity bit and one, one and a half or two high stop bits. All timing comes from a 16x oversampling tick made by an external divider, so one bit lasts 16 ticks.

A set of static control inputs picks the framing: word length, stop length, parity on or off, odd or even parity, forced (stick) parity, and a break override. Break pulls the line low but leaves the framing machine running, so software can keep using the transmitter to time a break. Two status outputs tell software when the holding register can take another character and when the whole transmitter has gone quiet. The control inputs are expected to stay unchanged while a frame is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is 1, and the holding-empty and transmitter-empty flags are both 1.
- R2: A frame starts with one low bit, sends data least significant bit first and holds each bit for 16 ticks. Between frames the line idles high.
- R3: `wordSel` sets the data bit count: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R4: The stop time is 16 ticks when `stopSel`=0. When `stopSel`=1 it is 24 ticks with 5-bit words and 32 ticks with 6, 7 or 8-bit words. `txEmpty` rises exactly when this time ends.
- R5: With `parityEn`=1, one parity bit goes between the last data bit and the stop bits. With `parityEn`=0, the frame has no parity bit.
- R6: With parity on and `stickSel`=0, `evenSel`=1 makes the count of ones in data plus parity even, and `evenSel`=0 makes it odd.
- R7: With parity on and `stickSel`=1, the parity bit is the inverse of `evenSel`.
- R8: While `breakSel`=1 the line output stays 0. The frame still runs to completion, so `txEmpty` rises after the same number of ticks as a normal frame. Clearing `breakSel` brings the idle line back to 1.
- R9: A write clears `holdEmpty` from the next cycle on. A second write before the character has moved to the shift register replaces it, and only the last one is sent.
- R10: On the first tick after the holding register fills with the line idle, the character moves to the shift register. `holdEmpty` then returns to 1 while `txEmpty` stays 0 until the last stop bit ends.
- R11: A write in the same cycle as a transfer tick keeps the new character in the holding register with `holdEmpty`=0. The older character is sent first, and the new one is sent right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the baud rate |
| wrEn | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Character to send |
| wordSel | input | 2 | Word length select |
| stopSel | input | 1 | Long stop select |
| parityEn | input | 1 | Parity bit enable |
| evenSel | input | 1 | Even parity select |
| stickSel | input | 1 | Forced parity select |
| breakSel | input | 1 | Holds the line low |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding register can take a character |
| txEmpty | output | 1 | Holding and shift registers both empty, line idle |

## Verification
A CPU write into the holding register and the tick that moves the held character into the shift register can land on the same clock edge. The bench lines up a write exactly on that transfer tick. It checks that `holdEmpty` stays low afterwards, and a scoreboard checks that both characters come out back to back and in order, each with correct bits and correct frame length. A second case places two writes between ticks and expects only the later character on the line.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

  typedef struct packed {
    logic loadShift;  // move holding register into shift register
    logic shiftBit;   // advance to next data bit
  } txStrobe_t;
endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       holdFull,
  input  logic [1:0] wordSel,
  input  logic       stopSel,
  input  logic       parityEn,
  output txState_t   state,
  output txStrobe_t  strobe
);
  localparam int CNT_W = $clog2(2 * OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W);

  logic [CNT_W-1:0] tickCnt, bitSpan;
  logic [BIT_W-1:0] bitCnt, lastBit;
  logic             bitDone;

  always_comb begin
    if (state == ST_STOP && stopSel)
      bitSpan = (wordSel == 2'b00) ? CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1)
                                   : CNT_W'(2 * OVERSAMPLE - 1);
    else
      bitSpan = CNT_W'(OVERSAMPLE - 1);
    lastBit = BIT_W'(DATA_W - 4) + BIT_W'(wordSel);
    bitDone = tick && (tickCnt == bitSpan);
    strobe.loadShift = tick && (state == ST_IDLE) && holdFull;
    strobe.shiftBit  = bitDone && (state == ST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (holdFull) begin
          state   <= ST_START;
          tickCnt <= '0;
        end
      end else if (!bitDone) begin
        tickCnt <= tickCnt + 1'b1;
      end else begin
        tickCnt <= '0;
        unique case (state)
          ST_START: begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
          ST_DATA: begin
            if (bitCnt == lastBit) state <= parityEn ? ST_PARITY : ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
          ST_PARITY: state <= ST_STOP;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: a full holding register starts a frame on the next tick
  p_load_starts_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && tick && holdFull) |=> state == ST_START);
  // R2: framing state only moves on ticks
  p_tick_paced_r2 : assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(state) && $stable(tickCnt)));
  // R3: data bit index never passes the programmed word length
  p_bit_bound_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> bitCnt <= lastBit);
endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wordSel,
  input  logic              parityEn,
  input  logic              evenSel,
  input  logic              stickSel,
  input  logic              breakSel,
  input  txState_t          state,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txOut
);
  logic [DATA_W-1:0] holdReg, shiftReg, wordMask;
  logic              parityBit, parityNext, lineBit;

  always_comb begin
    wordMask = {DATA_W{1'b1}} >> (2'd3 - wordSel);
    if (stickSel) parityNext = ~evenSel;
    else if (evenSel) parityNext = ^(holdReg & wordMask);
    else parityNext = ~^(holdReg & wordMask);
    unique case (state)
      ST_START:  lineBit = 1'b0;
      ST_DATA:   lineBit = shiftReg[0];
      ST_PARITY: lineBit = parityBit;
      default:   lineBit = 1'b1;
    endcase
    txOut = breakSel ? 1'b0 : lineBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      holdReg   <= '0;
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (wrEn) begin
        holdFull <= 1'b1;
        holdReg  <= wrData;
      end else if (strobe.loadShift) begin
        holdFull <= 1'b0;
      end
      if (strobe.loadShift) begin
        shiftReg  <= holdReg;
        parityBit <= parityEn & parityNext;
      end else if (strobe.shiftBit) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  // R9: a write fills the holding register with the written value
  p_write_fills_r9 : assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (holdFull && holdReg == $past(wrData)));
  // R10: a transfer without a competing write empties the holding register
  p_load_empties_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadShift && !wrEn) |=> !holdFull);
  // R11: the transfer takes the older character even when a write collides
  p_load_takes_old_r11 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadShift |=> shiftReg == $past(holdReg));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic [1:0] wordSel,
  input  logic       stopSel,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickSel,
  input  logic       breakSel,
  output logic       txOut,
  output logic       holdEmpty,
  output logic       txEmpty
);
  localparam int OVERSAMPLE = 16;
  localparam int DATA_W     = 8;

  txState_t  state;
  txStrobe_t strobe;
  logic      holdFull;

  sft_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .holdFull(holdFull),
    .wordSel(wordSel), .stopSel(stopSel), .parityEn(parityEn),
    .state(state), .strobe(strobe)
  );

  sft_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .wordSel(wordSel), .parityEn(parityEn), .evenSel(evenSel),
    .stickSel(stickSel), .breakSel(breakSel), .state(state),
    .strobe(strobe), .holdFull(holdFull), .txOut(txOut)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && (state == ST_IDLE);
endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] wordSel = 2'b11;
  logic       stopSel = 1'b0, parityEn = 1'b0, evenSel = 1'b0;
  logic       stickSel = 1'b0, breakSel = 1'b0;
  logic       txOut, holdEmpty, txEmpty;

  int testsRun = 0, testsFailed = 0;
  bit monOn = 1'b0;
  int divCnt = 0;

  typedef struct {
    logic [11:0] bits;
    int          nBits;
    int          endTicks;
    string       tag;
  } frame_t;
  frame_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .wordSel(wordSel), .stopSel(stopSel), .parityEn(parityEn),
    .evenSel(evenSel), .stickSel(stickSel), .breakSel(breakSel),
    .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  always @(negedge clk) begin
    divCnt <= (divCnt == 3) ? 0 : divCnt + 1;
    tick   <= (divCnt == 3);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic frame_t mkFrame(input logic [7:0] d, input string tag);
    frame_t f;
    int n, idx;
    logic [7:0] m;
    logic par;
    n = 5 + int'(wordSel);
    f.bits = '0;
    f.tag = tag;
    for (int i = 0; i < n; i++) f.bits[1+i] = d[i];
    idx = 1 + n;
    m = d & (8'hFF >> (8 - n));
    if (parityEn) begin
      if (stickSel) par = ~evenSel;
      else par = evenSel ? ^m : ~^m;
      f.bits[idx] = par;
      idx++;
    end
    f.bits[idx] = 1'b1;
    f.nBits = idx + 1;
    f.endTicks = 16 * idx + (stopSel ? ((n == 5) ? 24 : 32) : 16);
    return f;
  endfunction

  task automatic setCfg(input logic [1:0] ws, input logic ss, pe, es, sp);
    @(negedge clk);
    wordSel = ws; stopSel = ss; parityEn = pe; evenSel = es; stickSel = sp;
  endtask

  task automatic writeChar(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] d, input string tag);
    expQ.push_back(mkFrame(d, tag));
    writeChar(d);
    do @(negedge clk); while (!txEmpty);
    repeat (3) @(negedge clk);
  endtask

  // monitor: times each frame from its start bit and compares with the queue
  initial begin
    bit carry = 1'b0;
    forever begin
      frame_t e;
      logic [11:0] got;
      int cnt, endc;
      bit t;
      if (!carry) begin
        do @(negedge clk); while (!(monOn && txOut === 1'b0));
      end
      carry = 1'b0;
      cnt = 0; endc = -1; got = '0;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected frame", 0, 1);
        e.bits = '0; e.nBits = 2; e.endTicks = 0; e.tag = "R2";
      end else e = expQ.pop_front();
      while (endc < 0) begin
        @(posedge clk); t = tick;
        @(negedge clk);
        if (t) begin
          cnt++;
          if (cnt % 16 == 8 && cnt / 16 < e.nBits) got[cnt/16] = txOut;
        end
        if (txEmpty) endc = cnt;
        else if (cnt >= 16 * (e.nBits - 1) && txOut === 1'b0) begin
          endc = cnt - 1;
          carry = 1'b1;
        end
      end
      check(got == e.bits, {e.tag, " frame bits"}, int'(got), int'(e.bits));
      check(endc == e.endTicks, {e.tag, " frame ticks"}, endc, e.endTicks);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int n;
    bit bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txOut === 1'b1 && holdEmpty === 1'b1 && txEmpty === 1'b1, "R1 in reset",
          {txOut, holdEmpty, txEmpty}, 3'b111);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txOut === 1'b1 && holdEmpty === 1'b1 && txEmpty === 1'b1, "R1 after reset",
          {txOut, holdEmpty, txEmpty}, 3'b111);
    monOn = 1'b1;

    // R9 / R10 status sequence on an 8N1 frame (R2)
    setCfg(2'b11, 0, 0, 0, 0);
    expQ.push_back(mkFrame(8'hA5, "R2 8N1"));
    writeChar(8'hA5);
    check(holdEmpty === 1'b0 && txEmpty === 1'b0, "R9 write clears empty",
          {holdEmpty, txEmpty}, 2'b00);
    do @(negedge clk); while (!holdEmpty);
    check(txEmpty === 1'b0 && txOut === 1'b0, "R10 transfer frees holding",
          {txEmpty, txOut}, 2'b00);
    do @(negedge clk); while (!txEmpty);
    repeat (3) @(negedge clk);

    // R3 word lengths, R4 stop lengths
    setCfg(2'b00, 0, 0, 0, 0); sendChar(8'h16, "R3 5N1");
    setCfg(2'b01, 0, 0, 0, 0); sendChar(8'h2D, "R3 6N1");
    setCfg(2'b10, 0, 0, 0, 0); sendChar(8'h55, "R3 7N1");
    setCfg(2'b00, 1, 0, 0, 0); sendChar(8'h0B, "R4 5N1.5");
    setCfg(2'b10, 1, 0, 0, 0); sendChar(8'h3C, "R4 7N2");
    setCfg(2'b11, 1, 0, 0, 0); sendChar(8'hFF, "R4 8N2");

    // R5 / R6 parity, R7 stick parity
    setCfg(2'b11, 0, 1, 1, 0); sendChar(8'h07, "R6 even");
    setCfg(2'b11, 0, 1, 0, 0); sendChar(8'h07, "R6 odd");
    setCfg(2'b01, 0, 1, 0, 0); sendChar(8'hC0, "R5 parity 6 bit");
    setCfg(2'b11, 0, 1, 1, 1); sendChar(8'h81, "R7 stick even");
    setCfg(2'b00, 1, 1, 0, 1); sendChar(8'h1F, "R7 stick odd");

    // R9 overwrite: two writes between ticks, only the second is sent
    setCfg(2'b11, 0, 0, 0, 0);
    do @(posedge clk); while (!tick);
    expQ.push_back(mkFrame(8'h5A, "R9 overwrite"));
    @(negedge clk); wrEn = 1'b1; wrData = 8'h11;
    @(negedge clk); wrData = 8'h5A;
    @(negedge clk); wrEn = 1'b0;
    do @(negedge clk); while (!txEmpty);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R9 one frame only", expQ.size(), 0);

    // R11 write on the transfer tick
    do @(posedge clk); while (!tick);
    expQ.push_back(mkFrame(8'hC3, "R11 first"));
    expQ.push_back(mkFrame(8'h3C, "R11 second"));
    @(negedge clk); wrEn = 1'b1; wrData = 8'hC3;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; wrData = 8'h3C;
    @(negedge clk); wrEn = 1'b0;
    check(holdEmpty === 1'b0 && txOut === 1'b0, "R11 held after collision",
          {holdEmpty, txOut}, 2'b00);
    do @(negedge clk); while (!txEmpty);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 both frames sent", expQ.size(), 0);

    // R8 break keeps line low while timing continues
    monOn = 1'b0;
    setCfg(2'b11, 0, 0, 0, 0);
    @(negedge clk); breakSel = 1'b1;
    writeChar(8'hFF);
    n = 0; bad = 1'b0;
    do begin
      @(posedge clk); if (tick) n++;
      @(negedge clk); if (txOut !== 1'b0) bad = 1'b1;
    end while (!txEmpty);
    check(!bad, "R8 line low in break", bad, 0);
    check(n == 161, "R8 break frame ticks", n, 161);
    breakSel = 1'b0;
    @(negedge clk);
    check(txOut === 1'b1, "R8 idle after break", txOut, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule